// File: doc/BRIEF.md
# Debug-Commanded Reset Sequencer

This block lets a debug port reset the chip without the external reset pin. The debug logic decodes two commands, "enter reset" and "leave reset", and presents each one as a single-cycle strobe in the peripheral clock domain. The sequencer turns these strobes into an active-high on-chip reset with different delays on entry and on exit.

Reset becomes active after a short fixed delay. It is released only after a hold period, whose length is set by a configuration input and clamped to a bounded window. A 2-bit status code tells the debug host whether the processor runs normally or is held in reset. A one-cycle pulse clears only the overflow counter of the watchdog; the rest of the watchdog stays as it is. The time between the two commands is left to the host, so reset stays active for as long as no leave command arrives.

Top module: `dbg_reset_seq`

## Requirements
- R1: When `cmd_assert` is sampled high at rising edge k while the sequencer is idle, `chip_rst` is 0 after edges k+1 to k+3 and becomes 1 after edge k+4.
- R2: When `cmd_negate` is sampled high at edge m while reset is active and no release is running, `chip_rst` stays 1 and falls after edge m+N, where N is the hold length.
- R3: The hold length N is `hold_cfg` (6-bit, unsigned) clamped to the range 17 to 42. It is sampled at the edge where the hold starts.
- R4: `status` reads 2'b11 in every cycle where `chip_rst` is 1 and 2'b00 in every other cycle. It changes on the same edge as `chip_rst`.
- R5: `wdt_ovf_clr` is high for exactly one cycle: the first cycle in which `chip_rst` is 1.
- R6: `cmd_negate` has no effect while the sequencer is idle. It also has no effect while a release is already counting; it does not restart the hold.
- R7: `cmd_assert` has no effect once the sequencer has left idle. A repeated strobe during the entry delay does not restart it, and a strobe during reset issues no new clear pulse.
- R8: A `cmd_negate` that arrives during the entry delay is remembered. The hold then starts at the edge where `chip_rst` becomes 1, so reset falls N edges after that edge.
- R9: `por_n` low forces the sequencer at once into idle: `chip_rst` 0, `status` 2'b00, `wdt_ovf_clr` 0, and no remembered command.
- R10: Without a `cmd_negate`, `chip_rst` stays 1 for as long as no power-on reset occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cmd_assert | input | 1 | Single-cycle strobe: enter reset |
| cmd_negate | input | 1 | Single-cycle strobe: leave reset |
| hold_cfg | input | 6 | Requested hold length in cycles, clamped to 17..42 |
| chip_rst | output | 1 | On-chip reset, active high |
| status | output | 2 | 2'b00 normal operation, 2'b11 held in reset |
| wdt_ovf_clr | output | 1 | One-cycle clear pulse for the watchdog overflow counter |

## Verification
The hardest case to reach is a leave command that falls inside the four-cycle entry delay, in particular on the very edge at which reset turns on. A reordering bug there either drops the command or starts the hold too early. The stimulus counts falling edges from the enter strobe and places the leave strobe at fixed offsets inside that window. The bench then measures how many cycles reset stays high. A behavioural model that runs alongside the design catches any one-cycle slip on every clock. This also covers a leave command repeated during a running hold and clamp values at both ends of the range.

// File: rtl/dbg_reset_seq.sv
module dbg_reset_seq #(
  parameter int ARM_CYCLES = 4,
  parameter int HOLD_MIN   = 17,
  parameter int HOLD_MAX   = 42,
  parameter int CFG_W      = 6
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             cmd_assert,
  input  logic             cmd_negate,
  input  logic [CFG_W-1:0] hold_cfg,
  output logic             chip_rst,
  output logic [1:0]       status,
  output logic             wdt_ovf_clr
);

  localparam int CNT_MAX = (HOLD_MAX > ARM_CYCLES) ? HOLD_MAX : ARM_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_ACTIVE, S_HOLD} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hold_len;
  logic             pend;
  logic             clr_q;

  always_comb begin
    if (int'(hold_cfg) < HOLD_MIN)      hold_len = CNT_W'(HOLD_MIN);
    else if (int'(hold_cfg) > HOLD_MAX) hold_len = CNT_W'(HOLD_MAX);
    else                                hold_len = CNT_W'(hold_cfg);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      pend  <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      case (st)
        S_IDLE: if (cmd_assert) begin
          st   <= S_ARM;
          cnt  <= CNT_W'(ARM_CYCLES - 1);
          pend <= 1'b0;
        end
        S_ARM: begin
          if (cmd_negate) pend <= 1'b1;
          if (cnt == '0) begin
            clr_q <= 1'b1;
            pend  <= 1'b0;
            if (pend || cmd_negate) begin
              st  <= S_HOLD;
              cnt <= hold_len - CNT_W'(1);
            end else begin
              st  <= S_ACTIVE;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_ACTIVE: if (cmd_negate) begin
          st  <= S_HOLD;
          cnt <= hold_len - CNT_W'(1);
        end
        S_HOLD: begin
          if (cnt == '0) st <= S_IDLE;
          else           cnt <= cnt - CNT_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign chip_rst    = (st == S_ACTIVE) || (st == S_HOLD);
  assign status      = {chip_rst, chip_rst};
  assign wdt_ovf_clr = clr_q;

  logic [CNT_W:0] hold_age;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            hold_age <= '0;
    else if (st == S_HOLD) hold_age <= hold_age + 1'b1;
    else                   hold_age <= '0;
  end

  a_r1_rise_after_arm: assert property (@(posedge clk) disable iff (!por_n)
    $rose(chip_rst) |-> $past(st) == S_ARM);

  a_r3_hold_window: assert property (@(posedge clk) disable iff (!por_n)
    $fell(chip_rst) |-> (int'(hold_age) >= HOLD_MIN && int'(hold_age) <= HOLD_MAX));

  a_r4_status_code: assert property (@(posedge clk) disable iff (!por_n)
    status == 2'b00 || status == 2'b11);

  a_r5_clr_on_rise: assert property (@(posedge clk) disable iff (!por_n)
    wdt_ovf_clr |-> $rose(chip_rst));

  a_r5_clr_single: assert property (@(posedge clk) disable iff (!por_n)
    wdt_ovf_clr |=> !wdt_ovf_clr);

  a_r6_idle_negate: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_IDLE && !cmd_assert) |=> !chip_rst);

  a_r7_no_rearm: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_ARM && cmd_assert && cnt != '0) |=> (st == S_ARM && cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: tb/dbg_reset_seq_tb.sv
module dbg_reset_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ARM = 4;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       cmd_assert = 1'b0;
  logic       cmd_negate = 1'b0;
  logic [5:0] hold_cfg = 6'd0;
  logic       chip_rst;
  logic [1:0] status;
  logic       wdt_ovf_clr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  dbg_reset_seq dut_i (
    .clk(clk), .por_n(por_n), .cmd_assert(cmd_assert), .cmd_negate(cmd_negate),
    .hold_cfg(hold_cfg), .chip_rst(chip_rst), .status(status), .wdt_ovf_clr(wdt_ovf_clr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int clampn(input int v);
    if (v < 17) return 17;
    if (v > 42) return 42;
    return v;
  endfunction

  // behavioural reference model
  int m_rst, m_clr, arm_age, pend, hold_rem;
  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_rst = 0; m_clr = 0; arm_age = -1; pend = 0; hold_rem = 0;
    end else begin
      m_clr = 0;
      if (hold_rem > 0) begin
        hold_rem = hold_rem - 1;
        if (hold_rem == 0) m_rst = 0;
      end else if (arm_age >= 0) begin
        arm_age = arm_age + 1;
        if (cmd_negate) pend = 1;
        if (arm_age == ARM) begin
          arm_age = -1; m_rst = 1; m_clr = 1;
          if (pend != 0) hold_rem = clampn(int'(hold_cfg));
          pend = 0;
        end
      end else if (m_rst != 0) begin
        if (cmd_negate) hold_rem = clampn(int'(hold_cfg));
      end else if (cmd_assert) begin
        arm_age = 0; pend = 0;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (por_n && !done) begin
    chk("R2", "model chip_rst", int'(chip_rst), m_rst);
    chk("R4", "model status", int'(status), m_rst != 0 ? 3 : 0);
    chk("R5", "model wdt_ovf_clr", int'(wdt_ovf_clr), m_clr);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic s_assert();
    @(negedge clk) cmd_assert = 1'b1;
    @(negedge clk) cmd_assert = 1'b0;
  endtask
  task automatic s_negate();
    @(negedge clk) cmd_negate = 1'b1;
    @(negedge clk) cmd_negate = 1'b0;
  endtask
  task automatic count_high(output int n);
    n = 0;
    while (chip_rst && n < 200) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    idle(2);
    chk("R9", "reset chip_rst", int'(chip_rst), 0);
    chk("R9", "reset status", int'(status), 0);
    por_n = 1'b1;
    idle(3);

    // R1 / R5 / R4 / R10 and clamp low
    s_assert();
    idle(3); chk("R1", "rst before 4th edge", int'(chip_rst), 0);
    idle(1); chk("R1", "rst at 4th edge", int'(chip_rst), 1);
    chk("R5", "clr first cycle", int'(wdt_ovf_clr), 1);
    idle(1); chk("R5", "clr second cycle", int'(wdt_ovf_clr), 0);
    chk("R4", "status in reset", int'(status), 3);
    idle(30); chk("R10", "rst held without negate", int'(chip_rst), 1);
    hold_cfg = 6'd0; s_negate(); count_high(n);
    chk("R3", "hold clamp low", n, 17);
    chk("R4", "status after release", int'(status), 0);

    // R3 clamp high and in range
    s_assert(); idle(5); hold_cfg = 6'd63; s_negate(); count_high(n);
    chk("R3", "hold clamp high", n, 42);
    s_assert(); idle(5); hold_cfg = 6'd30; s_negate(); count_high(n);
    chk("R2", "hold in range", n, 30);

    // R6: negate while idle, then during a running hold
    s_negate(); idle(5); chk("R6", "idle negate no reset", int'(chip_rst), 0);
    s_assert(); idle(20); chk("R6", "stale negate not applied", int'(chip_rst), 1);
    hold_cfg = 6'd20; s_negate(); idle(5); hold_cfg = 6'd42; s_negate(); count_high(n);
    chk("R6", "second negate no restart", n, 13);

    // R7: repeated assert during arming and during reset
    s_assert(); s_assert();
    idle(1); chk("R7", "no rearm edge k+3", int'(chip_rst), 0);
    idle(1); chk("R7", "rise at k+4", int'(chip_rst), 1);
    idle(3); s_assert(); idle(3); chk("R7", "assert in reset no clr", int'(wdt_ovf_clr), 0);
    hold_cfg = 6'd17; s_negate(); count_high(n);
    chk("R7", "release after extra assert", n, 17);

    // R8: negate during arming, and on the very edge reset turns on
    hold_cfg = 6'd25; s_assert(); s_negate(); idle(2); count_high(n);
    chk("R8", "early negate hold", n, 25);
    idle(2);
    hold_cfg = 6'd18;
    @(negedge clk) cmd_assert = 1'b1;
    @(negedge clk) cmd_assert = 1'b0;
    idle(2);
    @(negedge clk) cmd_negate = 1'b1;
    @(negedge clk) cmd_negate = 1'b0;
    count_high(n);
    chk("R8", "negate on rise edge", n, 18);

    // R9: power-on reset in the middle of reset
    idle(2); s_assert(); idle(6);
    @(negedge clk) por_n = 1'b0;
    #1;
    chk("R9", "por clears rst", int'(chip_rst), 0);
    chk("R9", "por clears status", int'(status), 0);
    @(negedge clk) por_n = 1'b1;
    idle(10); chk("R9", "idle after por", int'(chip_rst), 0);

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule